// File: doc/BRIEF.md
# JTAG instruction decode and test control

This block sits behind a boundary-scan TAP controller and turns the instruction the TAP has latched into the actions that instruction implies. It chooses which data register is connected between `tdi` and `tdo`: a one-bit bypass cell, a small private test-control register, or a four-cell boundary register model. It also drives the pin-control outputs (an output-enable kill, a mux between functional pin values and boundary update cells) and an internal reset for the system logic.

The TAP controller supplies state strobes as levels that change just after the rising `tclk` edge: test-logic-reset, capture-DR, shift-DR, update-DR, shift-IR and update-IR. It also supplies the instruction code and the serial output of its own instruction register. A new instruction takes effect on the rising edge that ends an Update-IR cycle. Data registers capture and shift on rising edges. `tdo` is retimed on falling edges. All state is held in edge-triggered flops, so the clock can stop in either phase with nothing lost.

Top module: `jtag_instr_ctrl`

## Requirements
- R1: Opcodes are 4 bits: EXTEST 0x0, SAMPLE/PRELOAD 0x1, HIGHZ 0x9, CLAMP 0xC, TEST-CONTROL 0xD, BYPASS 0xF. Any other code behaves exactly as BYPASS. Under BYPASS, HIGHZ, CLAMP and undefined codes the scan path is one bit long.
- R2: At the rising edge that ends a Capture-DR cycle, the bypass cell is loaded with 0, so the first bit shifted out of a bypass path is 0 whatever was shifted in earlier.
- R3: While HIGHZ is in effect, every bit of `pad_oe` is 0.
- R4: `sys_rst` is 1 while HIGHZ or CLAMP is in effect, and 0 under every other instruction.
- R5: While CLAMP is in effect, `pad_data` equals the boundary update cells. Shifting and Update-DR under CLAMP leave those cells, and so `pad_data`, unchanged.
- R6: TEST-CONTROL connects a 3-bit register that shifts LSB first toward `tdo` and captures the current hold value at Capture-DR. `tc_hold` takes the shifted value at Update-DR and changes at no other time except test-logic-reset.
- R7: `tdo` and `tdo_oe` change only on falling `tclk` edges. `tdo_oe` is 1 exactly during Shift-DR or Shift-IR, and in Shift-IR `tdo` follows `ir_so`.
- R8: `sys_rst`, `pad_oe` override and the `pad_data` source change only when an Update-IR cycle completes. A change of `ir_code` with no Update-IR has no effect.
- R9: Test-logic-reset clears `sys_rst`, the pin overrides, `tc_hold` and the boundary update cells, and selects BYPASS.
- R10: The boundary path is 4 bits, LSB first. Capture-DR loads `func_data` into it, and Update-DR copies it to the update cells. EXTEST drives `pad_data` from the update cells. SAMPLE/PRELOAD leaves `pad_data` equal to `func_data`.
- R11: With `tclk` stopped, held values and outputs stay unchanged, and operation resumes correctly when the clock restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Test clock |
| st_tlr | input | 1 | TAP in Test-Logic-Reset |
| st_capture_dr | input | 1 | TAP in Capture-DR |
| st_shift_dr | input | 1 | TAP in Shift-DR |
| st_update_dr | input | 1 | TAP in Update-DR |
| st_shift_ir | input | 1 | TAP in Shift-IR |
| st_update_ir | input | 1 | TAP in Update-IR |
| ir_code | input | 4 | Latched instruction code |
| ir_so | input | 1 | Serial output of the instruction register |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| func_data | input | 4 | Functional pin output values |
| func_oe | input | 4 | Functional pin output enables |
| pad_data | output | 4 | Values driven to the pins |
| pad_oe | output | 4 | Enables driven to the pins |
| sys_rst | output | 1 | Internal reset for the system logic |
| tc_hold | output | 3 | Parallel hold of the test-control register |

## Verification
The bench measures the scan path length for every opcode, including an undefined one. A decoder that fell through to the boundary or test-control path on an unknown code would show a length of 3 or 4 instead of 1. It shifts ones through the bypass cell before a capture, so a design that kept the old bit instead of capturing 0 would shift a 1 out first. Under CLAMP it performs a full shift and Update-DR, so cells that took the update would move `pad_data`. It also samples `tdo` between a rising and the next falling edge, where a rising-edge-timed output would already have changed. It changes `ir_code` without Update-IR and stops the clock, and expects the outputs not to move in either case.

// File: rtl/jtag_instr_ctrl.sv
module jtag_instr_ctrl #(
  parameter int PINS = 4,
  parameter int IR_W = 4,
  parameter int TC_W = 3,
  parameter logic [IR_W-1:0] OP_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] OP_SAMPLE = 4'h1,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 4'h9,
  parameter logic [IR_W-1:0] OP_CLAMP  = 4'hC,
  parameter logic [IR_W-1:0] OP_TCTRL  = 4'hD
) (
  input  logic            tclk,
  input  logic            st_tlr,
  input  logic            st_capture_dr,
  input  logic            st_shift_dr,
  input  logic            st_update_dr,
  input  logic            st_shift_ir,
  input  logic            st_update_ir,
  input  logic [IR_W-1:0] ir_code,
  input  logic            ir_so,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic [PINS-1:0] func_data,
  input  logic [PINS-1:0] func_oe,
  output logic [PINS-1:0] pad_data,
  output logic [PINS-1:0] pad_oe,
  output logic            sys_rst,
  output logic [TC_W-1:0] tc_hold
);
  localparam logic [IR_W-1:0] OP_BYPASS = {IR_W{1'b1}};

  typedef enum logic [1:0] {PATH_BYP, PATH_BSR, PATH_TC} path_e;

  path_e           path_q, path_d;
  logic            highz_q, clamp_q, drive_q;
  logic            highz_d, clamp_d, drive_d;
  logic            byp_q;
  logic [TC_W-1:0] tc_sr;
  logic [PINS-1:0] bsr_sr, bsr_upd;
  logic            dr_lsb;

  always_comb begin
    path_d  = PATH_BYP;
    highz_d = 1'b0;
    clamp_d = 1'b0;
    drive_d = 1'b0;
    case (ir_code)
      OP_EXTEST: begin path_d = PATH_BSR; drive_d = 1'b1; end
      OP_SAMPLE: path_d = PATH_BSR;
      OP_HIGHZ:  highz_d = 1'b1;
      OP_CLAMP:  begin clamp_d = 1'b1; drive_d = 1'b1; end
      OP_TCTRL:  path_d = PATH_TC;
      OP_BYPASS: path_d = PATH_BYP;
      default:   path_d = PATH_BYP;
    endcase
  end

  always_ff @(posedge tclk) begin
    if (st_tlr) begin
      path_q  <= PATH_BYP;
      highz_q <= 1'b0;
      clamp_q <= 1'b0;
      drive_q <= 1'b0;
    end else if (st_update_ir) begin
      path_q  <= path_d;
      highz_q <= highz_d;
      clamp_q <= clamp_d;
      drive_q <= drive_d;
    end
  end

  always_ff @(posedge tclk) begin
    if (st_tlr || st_capture_dr) byp_q <= 1'b0;
    else if (st_shift_dr && path_q == PATH_BYP) byp_q <= tdi;
  end

  always_ff @(posedge tclk) begin
    if (st_tlr) begin
      tc_sr   <= '0;
      tc_hold <= '0;
    end else if (path_q == PATH_TC) begin
      if (st_capture_dr)     tc_sr   <= tc_hold;
      else if (st_shift_dr)  tc_sr   <= {tdi, tc_sr[TC_W-1:1]};
      else if (st_update_dr) tc_hold <= tc_sr;
    end
  end

  always_ff @(posedge tclk) begin
    if (st_tlr) begin
      bsr_sr  <= '0;
      bsr_upd <= '0;
    end else if (path_q == PATH_BSR) begin
      if (st_capture_dr)     bsr_sr  <= func_data;
      else if (st_shift_dr)  bsr_sr  <= {tdi, bsr_sr[PINS-1:1]};
      else if (st_update_dr) bsr_upd <= bsr_sr;
    end
  end

  always_comb begin
    case (path_q)
      PATH_BSR: dr_lsb = bsr_sr[0];
      PATH_TC:  dr_lsb = tc_sr[0];
      default:  dr_lsb = byp_q;
    endcase
  end

  always_ff @(negedge tclk) begin
    tdo_oe <= st_shift_dr | st_shift_ir;
    if (st_shift_ir)      tdo <= ir_so;
    else if (st_shift_dr) tdo <= dr_lsb;
  end

  assign sys_rst  = highz_q | clamp_q;
  assign pad_oe   = highz_q ? '0 : func_oe;
  assign pad_data = drive_q ? bsr_upd : func_data;
endmodule

// File: rtl/jtag_instr_ctrl_chk.sv
module jtag_instr_ctrl_chk #(
  parameter int PINS = 4,
  parameter int IR_W = 4,
  parameter int TC_W = 3,
  parameter logic [IR_W-1:0] OP_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 4'h9
) (
  input logic            tclk,
  input logic            st_tlr,
  input logic            st_capture_dr,
  input logic            st_shift_dr,
  input logic            st_update_dr,
  input logic            st_shift_ir,
  input logic            st_update_ir,
  input logic [IR_W-1:0] ir_code,
  input logic            sys_rst,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_data,
  input logic            tdo_oe,
  input logic [TC_W-1:0] tc_hold,
  input logic            byp_q,
  input logic [PINS-1:0] bsr_upd
);
  logic armed = 1'b0;
  always_ff @(posedge tclk) armed <= armed | st_tlr;

  assert_bypass_zero_R2: assert property (@(posedge tclk) disable iff (!armed)
    ($past(st_capture_dr) && !$past(st_tlr)) |-> (byp_q == 1'b0));

  assert_highz_oe_off_R3: assert property (@(posedge tclk) disable iff (st_tlr || !armed)
    ($past(st_update_ir) && !$past(st_tlr) && $past(ir_code) == OP_HIGHZ) |-> (pad_oe == '0 && sys_rst));

  assert_hold_only_update_R6: assert property (@(posedge tclk) disable iff (st_tlr || !armed)
    !st_update_dr |=> $stable(tc_hold));

  assert_tdo_oe_shift_R7: assert property (@(posedge tclk) disable iff (!armed)
    tdo_oe == (st_shift_dr || st_shift_ir));

  assert_rst_only_update_ir_R8: assert property (@(posedge tclk) disable iff (st_tlr || !armed)
    !st_update_ir |=> $stable(sys_rst));

  assert_tlr_clears_R9: assert property (@(posedge tclk) disable iff (!armed)
    $past(st_tlr) |-> (!sys_rst && tc_hold == '0 && bsr_upd == '0));

  assert_extest_drives_R10: assert property (@(posedge tclk) disable iff (st_tlr || !armed)
    ($past(st_update_ir) && !$past(st_tlr) && $past(ir_code) == OP_EXTEST) |-> (pad_data == bsr_upd));
endmodule

bind jtag_instr_ctrl jtag_instr_ctrl_chk #(
  .PINS(PINS), .IR_W(IR_W), .TC_W(TC_W), .OP_EXTEST(OP_EXTEST), .OP_HIGHZ(OP_HIGHZ)
) u_chk (.*);

// File: tb/test_jtag_instr_ctrl.sv
module test_jtag_instr_ctrl;
  logic       tclk = 1'b0;
  logic       run = 1'b1;
  logic       st_tlr, st_capture_dr, st_shift_dr, st_update_dr, st_shift_ir, st_update_ir;
  logic [3:0] ir_code;
  logic       ir_so, tdi, tdo, tdo_oe, sys_rst;
  logic [3:0] func_data, func_oe, pad_data, pad_oe;
  logic [2:0] tc_hold;

  int checks = 0;
  int errors = 0;
  logic so_q, oe_q;

  always #4 if (run) tclk = ~tclk;

  jtag_instr_ctrl i_jtag_instr_ctrl (.*);

  // code, rst, oe_off, drive, len
  localparam logic [10:0] VEC [7] = '{
    {4'h0, 1'b0, 1'b0, 1'b1, 4'd4},
    {4'h1, 1'b0, 1'b0, 1'b0, 4'd4},
    {4'h9, 1'b1, 1'b1, 1'b0, 4'd1},
    {4'hC, 1'b1, 1'b0, 1'b1, 4'd1},
    {4'hD, 1'b0, 1'b0, 1'b0, 4'd3},
    {4'hF, 1'b0, 1'b0, 1'b0, 4'd1},
    {4'h5, 1'b0, 1'b0, 1'b0, 4'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic st(input logic t, input logic c, input logic s, input logic u,
                    input logic sir, input logic uir);
    st_tlr = t; st_capture_dr = c; st_shift_dr = s; st_update_dr = u;
    st_shift_ir = sir; st_update_ir = uir;
  endtask

  task automatic step();
    @(negedge tclk); #1;
    so_q = tdo; oe_q = tdo_oe;
    @(posedge tclk); #1;
  endtask

  task automatic load_ir(input logic [3:0] c);
    ir_code = c; st(0,0,0,0,0,1); step(); st(0,0,0,0,0,0);
  endtask

  task automatic capture();
    st(0,1,0,0,0,0); step();
  endtask

  task automatic shift(input logic [7:0] din, input int n, output logic [7:0] dout);
    dout = '0;
    st(0,0,1,0,0,0);
    for (int i = 0; i < n; i++) begin
      tdi = din[i]; step(); dout[i] = so_q;
    end
    st(0,0,0,0,0,0);
  endtask

  task automatic update();
    st(0,0,0,1,0,0); step(); st(0,0,0,0,0,0);
  endtask

  task automatic dr_len(output int n);
    capture();
    st(0,0,1,0,0,0); tdi = 1'b1; n = -1;
    for (int i = 0; i < 8; i++) begin
      step();
      if (so_q === 1'b1 && n < 0) n = i;
    end
    st(0,0,0,0,0,0); step();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    logic a, b, c;
    st(1,0,0,0,0,0); ir_code = 4'hF; ir_so = 0; tdi = 0;
    func_data = 4'b0000; func_oe = 4'b1111;
    @(posedge tclk); #1; step(); step();
    st(0,0,0,0,0,0); step();
    // R9 reset state
    chk("R9 sys_rst after reset", sys_rst, 0);
    chk("R9 tc_hold after reset", tc_hold, 0);
    chk("R9 pad_data follows func", pad_data, func_data);
    chk("R9 pad_oe follows func", pad_oe, func_oe);
    chk("R7 tdo_oe idle", oe_q, 0);

    // R10 preload update cells 1010 via SAMPLE
    load_ir(4'h1); capture(); shift(8'b1010, 4, d); update();
    chk("R10 sample keeps pad_data functional", pad_data, func_data);

    // table walk: R1 R3 R4 R5 R10
    foreach (VEC[k]) begin
      load_ir(VEC[k][10:7]);
      chk("R4 sys_rst per opcode", sys_rst, VEC[k][6]);
      chk("R3 pad_oe per opcode", pad_oe, VEC[k][5] ? 4'b0000 : 4'b1111);
      chk("R5/R10 pad_data source", pad_data, VEC[k][4] ? 4'b1010 : 4'b0000);
      dr_len(n);
      chk("R1 path length", n, VEC[k][3:0]);
    end

    // R2 bypass capture forces 0 even after ones
    load_ir(4'hF); capture(); shift(8'hFF, 3, d); capture(); shift(8'hFF, 2, d);
    chk("R2 first bypass bit", d[0], 0);
    chk("R1 bypass second bit", d[1], 1);

    // R7 tdo changes on falling edge only
    capture(); st(0,0,1,0,0,0); tdi = 1'b1;
    @(negedge tclk); #1; a = tdo;
    @(posedge tclk); #1; b = tdo;
    @(negedge tclk); #1; c = tdo;
    @(posedge tclk); #1; st(0,0,0,0,0,0);
    chk("R7 tdo at first shift fall", a, 0);
    chk("R7 tdo held after rising edge", b, 0);
    chk("R7 tdo updates at falling edge", c, 1);
    st(0,0,0,0,1,0); ir_so = 1'b1; step();
    chk("R7 shift-IR tdo follows ir_so", so_q, 1);
    chk("R7 shift-IR tdo_oe", oe_q, 1);
    ir_so = 1'b0; step();
    chk("R7 shift-IR tdo follows ir_so low", so_q, 0);
    st(0,0,0,0,0,0); step();
    chk("R7 tdo_oe low outside shift", oe_q, 0);

    // R6 test-control register
    load_ir(4'hD); capture(); shift(8'b101, 3, d);
    chk("R6 hold unchanged before update", tc_hold, 0);
    update();
    chk("R6 hold after update", tc_hold, 3'b101);
    capture(); shift(8'b011, 3, d);
    chk("R6 captured hold shifted LSB first", d[2:0], 3'b101);
    step();
    chk("R6 hold unchanged without update", tc_hold, 3'b101);

    // R5 clamp ignores boundary updates
    load_ir(4'hC); capture(); shift(8'b0101, 4, d); update();
    chk("R5 clamp pad_data held", pad_data, 4'b1010);
    chk("R5 clamp sys_rst", sys_rst, 1);

    // R8 ir_code change without update-IR
    load_ir(4'h9); ir_code = 4'hF; step(); step();
    chk("R8 sys_rst kept", sys_rst, 1);
    chk("R8 pad_oe kept off", pad_oe, 0);

    // R10 sample captures pins, extest drives update cells
    func_data = 4'b0110;
    load_ir(4'h1); capture(); shift(8'b0011, 4, d);
    chk("R10 captured pins", d[3:0], 4'b0110);
    update();
    chk("R10 sample pad_data functional", pad_data, 4'b0110);
    load_ir(4'h0);
    chk("R10 extest pad_data from cells", pad_data, 4'b0011);

    // R11 stopped clock
    load_ir(4'hD); capture(); shift(8'b110, 3, d); update();
    run = 1'b0; #200;
    chk("R11 hold kept with clock stopped", tc_hold, 3'b110);
    chk("R11 pad_data kept with clock stopped", pad_data, func_data);
    run = 1'b1; @(posedge tclk); #1;
    capture(); shift(8'b000, 3, d);
    chk("R11 resumes after stop", d[2:0], 3'b110);

    // R9 reset from clamp
    update(); load_ir(4'hC);
    st(1,0,0,0,0,0); step(); st(0,0,0,0,0,0); step();
    chk("R9 sys_rst cleared", sys_rst, 0);
    chk("R9 hold cleared", tc_hold, 0);
    chk("R9 pad_data functional", pad_data, func_data);
    dr_len(n);
    chk("R9 bypass selected", n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule